// File: doc/BRIEF.md
# Next-PC and Link Unit

This block forms the address of the next instruction for a 64-bit load/store processor with fixed four-byte instructions. Each cycle the decoder presents the current PC, a control-flow kind, the raw target or immediate field of the instruction, and one register operand. The unit adds the instruction size to the PC and evaluates the branch condition. It builds the jump target in the selected mode and reports whether the transfer is taken. When linking is requested on an unconditional jump, it also produces a write of the return address into a fixed link register.

There are four ways to form a target. A direct jump splices a word-aligned 26-bit field into the low 28 bits of PC+4. A register jump uses the register value as is. A register-plus-offset jump adds a signed byte offset to the register. A PC-relative jump adds a signed word offset to PC+4. Conditional branches test one register against zero, with either polarity, and use the PC-relative form. A register-based target that is not word aligned raises an error flag. The result is registered, so it appears one cycle after the request. A parameter can select a purely combinational path instead.

Top module: `npc_link_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `res_valid`, `res_taken`, `lnk_we` and `res_misalign` are 0 and `res_pc` is 0.
- R2: Kind 0 (sequential) and the reserved kind 7 give `res_pc` = PC+4 with `res_taken` = 0, and the link request is ignored.
- R3: Kind 1 (branch if zero) is taken exactly when `src_val` is 0. The target is PC+4 plus the sign-extended low 16 bits of `tgt_field` shifted left by 2, and bits 25:16 of the field are ignored. When the branch is not taken, `res_pc` is PC+4.
- R4: Kind 2 (branch if non-zero) is taken exactly when `src_val` is not 0. It forms its target as in R3.
- R5: Kind 3 (direct jump) is always taken. `res_pc` keeps bits 63:28 of PC+4, takes bits 27:2 from `tgt_field[25:0]`, and has bits 1:0 at 0.
- R6: Kind 4 (register jump) is always taken, and `res_pc` equals `src_val`.
- R7: Kind 5 (register plus offset) is always taken. `res_pc` is `src_val` plus the sign-extended low 16 bits of `tgt_field`, not shifted.
- R8: Kind 6 (PC-relative jump) is always taken. `res_pc` is PC+4 plus the sign-extended low 16 bits of `tgt_field` shifted left by 2.
- R9: With `req_link` high and kind 3 to 6, `lnk_we` is 1, `lnk_idx` is 31 and `lnk_data` is PC+4. With kind 0, 1, 2 or 7, `lnk_we` stays 0.
- R10: For kinds 4 and 5, `res_misalign` is 1 when bits 1:0 of the target are not 00, and `res_pc` still carries that target. For every other kind it is 0.
- R11: Results appear on the cycle after `req_valid` is sampled high. A cycle with `req_valid` low yields `res_valid`, `res_taken`, `lnk_we` and `res_misalign` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| cur_pc | input | 64 | Address of the current instruction |
| cf_kind | input | 3 | Control-flow kind, 0 to 7 as listed in the requirements |
| req_link | input | 1 | Write the return address on an unconditional jump |
| tgt_field | input | 26 | Direct target field; low 16 bits are the signed offset |
| src_val | input | 64 | Register operand value |
| res_valid | output | 1 | Result present |
| res_pc | output | 64 | Next program counter |
| res_taken | output | 1 | Control transfer taken |
| res_misalign | output | 1 | Register-based target not word aligned |
| lnk_we | output | 1 | Link register write enable |
| lnk_idx | output | 5 | Link register index |
| lnk_data | output | 64 | Return address to write |

## Verification
The bench drives a direct jump from a PC whose increment carries across bit 28. A design that spliced into the unincremented PC would keep the old upper bits there. It fills the unused upper bits of the field with ones for branches and offsets, which exposes a design that sign-extends from the wrong bit. It also uses negative offsets, which would come out as large forward targets if zero-extended. The other cases are link requests on branches and sequential kinds, which must not write; misaligned register targets, which must flag but still redirect; and idle cycles between requests, which catch flags that stay high.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [2:0] {
      CF_SEQ   = 3'd0,
      CF_BEQZ  = 3'd1,
      CF_BNEZ  = 3'd2,
      CF_JDIR  = 3'd3,
      CF_JREG  = 3'd4,
      CF_JDISP = 3'd5,
      CF_JPCR  = 3'd6,
      CF_RSVD  = 3'd7
   } cf_kind_e;

   function automatic logic is_uncond(cf_kind_e k);
      return (k == CF_JDIR) || (k == CF_JREG) || (k == CF_JDISP) || (k == CF_JPCR);
   endfunction
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
   parameter int XLEN = 64,
   parameter int STEP = 4
) (
   input  logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] pc_inc
);
   if (STEP <= 0) begin : g_bad_step
      $error("npc_incr: STEP must be positive");
   end
   assign pc_inc = pc + XLEN'(STEP);
endmodule

// File: rtl/npc_zero_test.sv
module npc_zero_test #(
   parameter int XLEN    = 64,
   parameter int CHUNK_W = 8
) (
   input  logic [XLEN-1:0] val,
   output logic            is_zero
);
   localparam int NCHUNK = XLEN / CHUNK_W;

   if (CHUNK_W <= 0 || (XLEN % CHUNK_W) != 0) begin : g_bad_chunk
      $error("npc_zero_test: CHUNK_W must divide XLEN");
   end

   logic [NCHUNK-1:0] part_any;

   for (genvar g = 0; g < NCHUNK; g++) begin : g_chunk
      assign part_any[g] = |val[g*CHUNK_W +: CHUNK_W];
   end

   assign is_zero = ~|part_any;
endmodule

// File: rtl/npc_target.sv
module npc_target #(
   parameter int XLEN    = 64,
   parameter int FIELD_W = 26,
   parameter int DISP_W  = 16,
   parameter int ALIGN_W = 2
) (
   input  logic [XLEN-1:0]    pc_inc,
   input  logic [XLEN-1:0]    reg_val,
   input  logic [FIELD_W-1:0] field,
   output logic [XLEN-1:0]    tgt_rel,
   output logic [XLEN-1:0]    tgt_dir,
   output logic [XLEN-1:0]    tgt_reg,
   output logic [XLEN-1:0]    tgt_disp
);
   localparam int SPLICE_W = FIELD_W + ALIGN_W;

   if (DISP_W > FIELD_W) begin : g_bad_disp
      $error("npc_target: DISP_W must fit in FIELD_W");
   end
   if (SPLICE_W >= XLEN) begin : g_bad_splice
      $error("npc_target: splice must leave upper PC bits");
   end

   logic [DISP_W-1:0] disp;
   logic [XLEN-1:0]   disp_sx;
   logic [XLEN-1:0]   disp_words;

   assign disp       = field[DISP_W-1:0];
   assign disp_sx    = {{(XLEN-DISP_W){disp[DISP_W-1]}}, disp};
   assign disp_words = disp_sx << ALIGN_W;

   assign tgt_rel  = pc_inc + disp_words;
   assign tgt_dir  = {pc_inc[XLEN-1:SPLICE_W], field, {ALIGN_W{1'b0}}};
   assign tgt_reg  = reg_val;
   assign tgt_disp = reg_val + disp_sx;
endmodule

// File: rtl/npc_link_unit.sv
module npc_link_unit #(
   parameter int XLEN       = 64,
   parameter int FIELD_W    = 26,
   parameter int DISP_W     = 16,
   parameter int INSN_BYTES = 4,
   parameter int REG_IDX_W  = 5,
   parameter int LINK_REG   = 31,
   parameter int ZCHUNK_W   = 8,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [XLEN-1:0]      cur_pc,
   input  logic [2:0]           cf_kind,
   input  logic                 req_link,
   input  logic [FIELD_W-1:0]   tgt_field,
   input  logic [XLEN-1:0]      src_val,
   output logic                 res_valid,
   output logic [XLEN-1:0]      res_pc,
   output logic                 res_taken,
   output logic                 res_misalign,
   output logic                 lnk_we,
   output logic [REG_IDX_W-1:0] lnk_idx,
   output logic [XLEN-1:0]      lnk_data
);
   import npc_pkg::*;

   localparam int ALIGN_W  = $clog2(INSN_BYTES);
   localparam int SPLICE_W = FIELD_W + ALIGN_W;

   if ((1 << ALIGN_W) != INSN_BYTES || INSN_BYTES < 2) begin : g_bad_insn
      $error("npc_link_unit: INSN_BYTES must be a power of two");
   end
   if (LINK_REG >= (1 << REG_IDX_W)) begin : g_bad_link
      $error("npc_link_unit: LINK_REG out of index range");
   end

   cf_kind_e        kind;
   logic [XLEN-1:0] pc_inc;
   logic            src_zero;
   logic [XLEN-1:0] t_rel, t_dir, t_reg, t_disp;

   assign kind = cf_kind_e'(cf_kind);

   npc_incr #(.XLEN(XLEN), .STEP(INSN_BYTES)) u_incr (
      .pc     (cur_pc),
      .pc_inc (pc_inc)
   );

   npc_zero_test #(.XLEN(XLEN), .CHUNK_W(ZCHUNK_W)) u_zero (
      .val     (src_val),
      .is_zero (src_zero)
   );

   npc_target #(.XLEN(XLEN), .FIELD_W(FIELD_W), .DISP_W(DISP_W), .ALIGN_W(ALIGN_W)) u_tgt (
      .pc_inc   (pc_inc),
      .reg_val  (src_val),
      .field    (tgt_field),
      .tgt_rel  (t_rel),
      .tgt_dir  (t_dir),
      .tgt_reg  (t_reg),
      .tgt_disp (t_disp)
   );

   // selection of the target and the condition
   logic            c_take;
   logic            c_align_chk;
   logic [XLEN-1:0] c_tgt;

   always_comb begin
      c_take      = 1'b0;
      c_align_chk = 1'b0;
      c_tgt       = pc_inc;
      unique case (kind)
         CF_BEQZ:  begin c_take = src_zero;  c_tgt = t_rel;  end
         CF_BNEZ:  begin c_take = !src_zero; c_tgt = t_rel;  end
         CF_JDIR:  begin c_take = 1'b1;      c_tgt = t_dir;  end
         CF_JREG:  begin c_take = 1'b1;      c_tgt = t_reg;  c_align_chk = 1'b1; end
         CF_JDISP: begin c_take = 1'b1;      c_tgt = t_disp; c_align_chk = 1'b1; end
         CF_JPCR:  begin c_take = 1'b1;      c_tgt = t_rel;  end
         default:  begin c_take = 1'b0;      c_tgt = pc_inc; end
      endcase
   end

   logic            c_valid, c_taken, c_mis, c_lnk;
   logic [XLEN-1:0] c_pc;

   assign c_valid = req_valid;
   assign c_taken = req_valid && c_take;
   assign c_pc    = c_take ? c_tgt : pc_inc;
   assign c_mis   = req_valid && c_align_chk && (|c_tgt[ALIGN_W-1:0]);
   assign c_lnk   = req_valid && req_link && is_uncond(kind);

   assign lnk_idx = REG_IDX_W'(LINK_REG);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_valid    <= 1'b0;
            res_taken    <= 1'b0;
            res_misalign <= 1'b0;
            lnk_we       <= 1'b0;
            res_pc       <= '0;
            lnk_data     <= '0;
         end else begin
            res_valid    <= c_valid;
            res_taken    <= c_taken;
            res_misalign <= c_mis;
            lnk_we       <= c_lnk;
            if (c_valid) begin
               res_pc   <= c_pc;
               lnk_data <= pc_inc;
            end
         end
      end

      AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !res_valid |-> !(res_taken || lnk_we || res_misalign)) else $error("idle output active"); // R11
      AST_SEQ_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && !res_taken) |-> (res_pc == $past(cur_pc) + XLEN'(INSN_BYTES))) else $error("fall-through pc"); // R2
      AST_LINK_DATA: assert property (@(posedge clk) disable iff (!rst_n)
         lnk_we |-> (res_taken && lnk_data == $past(cur_pc) + XLEN'(INSN_BYTES))) else $error("link data"); // R9
      AST_LINK_NO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && $past(cf_kind) < 3'd3) |-> !lnk_we) else $error("link on branch"); // R9
      AST_DIRECT_SPLICE: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && $past(cf_kind) == 3'd3) |->
         ((res_pc >> SPLICE_W) == (($past(cur_pc) + XLEN'(INSN_BYTES)) >> SPLICE_W))) else $error("splice upper bits"); // R5
      AST_MISALIGN_REG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
         res_misalign |-> (res_taken && ($past(cf_kind) == 3'd4 || $past(cf_kind) == 3'd5))) else $error("misalign kind"); // R10
   end else begin : g_comb
      assign res_valid    = c_valid;
      assign res_taken    = c_taken;
      assign res_misalign = c_mis;
      assign lnk_we       = c_lnk;
      assign res_pc       = c_pc;
      assign lnk_data     = pc_inc;
   end
endmodule

// File: tb/sim_npc_link_unit.sv
module sim_npc_link_unit;
   localparam int XLEN = 64;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [XLEN-1:0]  cur_pc = '0;
   logic [2:0]       cf_kind = '0;
   logic             req_link = 1'b0;
   logic [25:0]      tgt_field = '0;
   logic [XLEN-1:0]  src_val = '0;
   logic             res_valid, res_taken, res_misalign, lnk_we;
   logic [XLEN-1:0]  res_pc, lnk_data;
   logic [4:0]       lnk_idx;

   always #4 clk = ~clk;   // 125 MHz

   npc_link_unit u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cur_pc(cur_pc),
      .cf_kind(cf_kind), .req_link(req_link), .tgt_field(tgt_field), .src_val(src_val),
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
      .res_misalign(res_misalign), .lnk_we(lnk_we), .lnk_idx(lnk_idx), .lnk_data(lnk_data)
   );

   typedef struct {
      string       tag;
      logic        v;
      logic [63:0] pc;
      logic        tk;
      logic        mis;
      logic        we;
      logic [63:0] ld;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   mon_on = 1'b0;
   bit   done = 1'b0;

   function automatic logic [63:0] sx16(logic [15:0] d);
      logic [63:0] r;
      r = {48'd0, d};
      if (d[15]) r = r - 64'h1_0000;
      return r;
   endfunction

   task automatic drive(string tag, logic v, logic [2:0] k, logic lk,
                        logic [25:0] f, logic [63:0] s, logic [63:0] pc);
      exp_t e;
      logic [63:0] nx;
      @(negedge clk);
      req_valid = v; cf_kind = k; req_link = lk; tgt_field = f; src_val = s; cur_pc = pc;
      nx = pc + 64'd4;
      e.tag = tag; e.v = v; e.pc = nx; e.tk = 1'b0; e.mis = 1'b0; e.we = 1'b0; e.ld = nx;
      case (k)
         3'd1: if (s == 64'd0) begin e.tk = 1'b1; e.pc = nx + sx16(f[15:0]) * 64'd4; end
         3'd2: if (s != 64'd0) begin e.tk = 1'b1; e.pc = nx + sx16(f[15:0]) * 64'd4; end
         3'd3: begin e.tk = 1'b1; e.pc = (nx & ~64'h0FFF_FFFF) | (64'(f) * 64'd4); end
         3'd4: begin e.tk = 1'b1; e.pc = s; e.mis = (s % 64'd4) != 0; end
         3'd5: begin e.tk = 1'b1; e.pc = s + sx16(f[15:0]); e.mis = (e.pc % 64'd4) != 0; end
         3'd6: begin e.tk = 1'b1; e.pc = nx + sx16(f[15:0]) * 64'd4; end
         default: ;
      endcase
      e.we = lk && (k >= 3'd3) && (k <= 3'd6);
      if (!v) begin e.tk = 1'b0; e.mis = 1'b0; e.we = 1'b0; end
      q.push_back(e);
   endtask

   // monitor: one expected item per cycle, compared just after the edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_on && q.size() > 0) begin
            exp_t e;
            bit bad;
            e = q.pop_front();
            bad = 1'b0;
            n_chk++;
            if (res_valid !== e.v || res_taken !== e.tk || res_misalign !== e.mis || lnk_we !== e.we) begin
               bad = 1'b1;
               $display("FAIL %s flags v/tk/mis/we = %b%b%b%b expected %b%b%b%b",
                        e.tag, res_valid, res_taken, res_misalign, lnk_we, e.v, e.tk, e.mis, e.we);
            end
            if (e.v && res_pc !== e.pc) begin
               bad = 1'b1;
               $display("FAIL %s res_pc = %h expected %h", e.tag, res_pc, e.pc);
            end
            if (e.we && (lnk_data !== e.ld || lnk_idx !== 5'd31)) begin
               bad = 1'b1;
               $display("FAIL %s link idx/data = %0d/%h expected 31/%h", e.tag, lnk_idx, lnk_data, e.ld);
            end
            if (bad) n_fail++;
         end
      end
   end

   initial begin
      #200_000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired before stimulus completed");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   localparam logic [63:0] PCA = 64'h0000_1234_5678_9ABC;
   localparam logic [63:0] PCB = 64'h0000_00AB_0FFF_FFFC;

   initial begin
      repeat (3) @(posedge clk);
      #1;
      n_chk++;   // R1 reset state
      if (res_valid !== 1'b0 || res_taken !== 1'b0 || lnk_we !== 1'b0 || res_misalign !== 1'b0 || res_pc !== 64'd0) begin
         n_fail++;
         $display("FAIL R1 reset outputs v/tk/we/mis=%b%b%b%b pc=%h expected 0000 pc=0",
                  res_valid, res_taken, lnk_we, res_misalign, res_pc);
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      n_chk++;   // R1 first cycle after reset
      if (res_valid !== 1'b0 || res_taken !== 1'b0 || lnk_we !== 1'b0 || res_misalign !== 1'b0) begin
         n_fail++;
         $display("FAIL R1 post-reset flags=%b%b%b%b expected 0000",
                  res_valid, res_taken, lnk_we, res_misalign);
      end
      mon_on = 1'b1;

      drive("R2 seq",            1, 3'd0, 0, 26'h0,       64'd5, PCA);
      drive("R2 seq link",       1, 3'd0, 1, 26'h3FF_FFFF, 64'd0, PCA);
      drive("R2 rsvd link",      1, 3'd7, 1, 26'h12,      64'd0, PCA);
      drive("R3 beqz taken",     1, 3'd1, 0, 26'h000_0010, 64'd0, PCA);
      drive("R3 beqz not",       1, 3'd1, 0, 26'h000_0010, 64'd1, PCA);
      drive("R3 beqz neg hi",    1, 3'd1, 0, 26'h3FF_FFF0, 64'd0, PCA);
      drive("R9 beqz link",      1, 3'd1, 1, 26'h000_0004, 64'd0, PCA);
      drive("R4 bnez taken",     1, 3'd2, 0, 26'h000_8000, 64'h8000_0000_0000_0000, PCA);
      drive("R4 bnez not",       1, 3'd2, 1, 26'h000_0020, 64'd0, PCA);
      drive("R11 idle",          0, 3'd3, 1, 26'h1,       64'd3, PCA);
      drive("R5 jdir link",      1, 3'd3, 1, 26'h155_5555, 64'd0, PCA);
      drive("R5 jdir carry",     1, 3'd3, 0, 26'h000_0001, 64'd0, PCB);
      drive("R5 jdir ones",      1, 3'd3, 0, 26'h3FF_FFFF, 64'd0, PCA);
      drive("R6 jreg link",      1, 3'd4, 1, 26'h3FF_FFFF, 64'hFFFF_0000_1234_5670, PCA);
      drive("R10 jreg mis",      1, 3'd4, 0, 26'h0,       64'h0000_0000_0000_1002, PCA);
      drive("R7 jdisp neg",      1, 3'd5, 0, 26'h3FF_FFF8, 64'h0000_0000_0000_1000, PCA);
      drive("R10 jdisp mis",     1, 3'd5, 1, 26'h000_0003, 64'h0000_0000_0000_2000, PCA);
      drive("R10 jdisp fix",     1, 3'd5, 0, 26'h000_0001, 64'h0000_0000_0000_2003, PCA);
      drive("R8 jpcr neg",       1, 3'd6, 0, 26'h000_FFFF, 64'd0, PCA);
      drive("R8 jpcr link",      1, 3'd6, 1, 26'h3FF_7FFF, 64'd0, PCB);
      drive("R11 idle2",         0, 3'd0, 0, 26'h0,       64'd0, PCA);
      drive("R11 back2back",     1, 3'd4, 1, 26'h0,       64'h0000_0000_0000_4001, PCB);
      drive("R11 idle3",         0, 3'd6, 1, 26'h0,       64'd0, PCA);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule